// File: doc/BRIEF.md
# Repeating Synthesizer Command Frame Sequencer

This block streams a fixed-shape command frame to a frequency synthesizer over a three-wire serial link and repeats that frame back to back for a set number of frames. Each frame carries an 8-bit command followed directly by a 16-bit data word, most significant bit first. The chip select is active low while the frame is on the wire. After the select is released, one idle serial period passes, and then a single update strobe, one serial period wide, tells the synthesizer to apply the frame.

The host side presents the command byte, the data word, a divisor and a frame count as plain inputs, and pulses `start_i`. The serial clock period is the divisor multiplied by the system clock period. A divisor below five is raised to five. The host may change the command and word while a burst runs. A new value reaches the wire only at the next frame boundary, so a frame is never split between an old and a new value. The burst window is set by the frame count, and the gap and strobe periods count toward it. `busy_o` stays high until the strobe of the last frame has finished.

Top module: `dds_frame_seq`

## Requirements
- R1: After synchronous reset, `cs_n_o` is 1 and `sclk_o`, `sdata_o`, `ioupd_o` and `busy_o` are 0.
- R2: Every frame has exactly 24 rising `sclk_o` edges while `cs_n_o` is 0. The bits sampled on those edges are the command byte, then the data word, each MSB first.
- R3: The link is mode 0. `sclk_o` idles low and is high only while `cs_n_o` is 0. `sdata_o` does not change while `sclk_o` is high.
- R4: With effective divisor D, rising `sclk_o` edges within a frame are D cycles apart, and each high phase of `sclk_o` lasts floor(D/2) cycles.
- R5: A `div_i` value below 5 behaves exactly as a divisor of 5.
- R6: After `cs_n_o` rises at the end of a frame, it stays high and `ioupd_o` stays low for D cycles. Then `ioupd_o` is high for exactly D cycles, and during that time `cs_n_o` is 1.
- R7: A burst of N frames keeps `busy_o` high for exactly N*26*D cycles and emits N frames and N strobes. The next frame's select falls right after the previous strobe ends.
- R8: The `cmd_i` and `word_i` values are captured at burst start and at each frame boundary. A change made mid-frame first appears in the next frame.
- R9: `start_i` has no effect while `busy_o` is 1, and also has no effect when `frames_i` is 0.

Each row of the Ports table describes one port of `dds_frame_seq`, in the order of its port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle burst start request |
| div_i | input | 8 | Serial clock divisor, clamped to at least 5 |
| frames_i | input | 16 | Number of frames in the burst |
| cmd_i | input | 8 | Command byte sent first in each frame |
| word_i | input | 16 | Data word sent after the command byte |
| sclk_o | output | 1 | Serial clock, idle low |
| sdata_o | output | 1 | Serial data, MSB first |
| cs_n_o | output | 1 | Active-low chip select |
| ioupd_o | output | 1 | Update strobe after each frame |
| busy_o | output | 1 | High for the duration of the burst |

## Verification
`busy_o` rises on the first clock edge after `start_i` is sampled. The four pin outputs are registered, so they trail the internal schedule by one cycle. As a result, each frame's pin activity is due one cycle after its slot in the N*26*D schedule.

The bench samples at the falling clock edge. It rebuilds each frame from the rising `sclk_o` edges, and it measures run lengths and edge spacings in whole cycles. This way every timing check is an exact count against D, and no check depends on a fixed absolute offset.

For the frame-boundary capture test, the inputs are changed only after the first frame's select has fallen. That change is therefore due exactly at the second frame.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  // slots per frame: data bits, one idle gap period, one strobe period
  localparam int unsigned GAP_SLOTS    = 1;
  localparam int unsigned STROBE_SLOTS = 1;

  typedef struct packed {
    logic sclk;
    logic sdata;
    logic cs_n;
    logic ioupd;
  } ser_pins_t;

  localparam ser_pins_t PINS_IDLE = '{sclk: 1'b0, sdata: 1'b0, cs_n: 1'b1, ioupd: 1'b0};

  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 1;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/dds_clk_div.sv
module dds_clk_div #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_MIN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             per_end_o,
  output logic             hi_phase_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] ph_q;
  logic [DIV_W-1:0] low_len;

  assign low_len    = div_q - (div_q >> 1);
  assign per_end_o  = run_i && (ph_q == div_q - 1'b1);
  assign hi_phase_o = (ph_q >= low_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_W'(DIV_MIN);
      ph_q  <= '0;
    end else if (load_i) begin
      div_q <= (div_i < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_i;
      ph_q  <= '0;
    end else if (run_i) begin
      ph_q <= per_end_o ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/dds_frame_shift.sv
module dds_frame_shift #(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              msb_o
);
  localparam int unsigned FR_W = CMD_W + WORD_W;
  logic [FR_W-1:0] sh_q;

  assign msb_o = sh_q[FR_W-1];

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (load_i)  sh_q <= {cmd_i, word_i};
    else if (shift_i) sh_q <= {sh_q[FR_W-2:0], 1'b0};
  end
endmodule

// File: rtl/dds_frame_ctrl.sv
module dds_frame_ctrl #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned FR_BITS = 24,
  parameter int unsigned SLOT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  frames_i,
  input  logic              per_end_i,
  output logic              accept_o,
  output logic              load_o,
  output logic              shift_o,
  output logic              busy_o,
  output logic              in_data_o,
  output logic              in_strobe_o
);
  import dds_seq_pkg::*;
  localparam int unsigned STROBE_SLOT = FR_BITS + GAP_SLOTS;

  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  logic              frame_end;
  logic              last_frame;

  assign accept_o    = start_i && !busy_q && (frames_i != '0);
  assign frame_end   = busy_q && per_end_i && (slot_q == SLOT_W'(STROBE_SLOT));
  assign last_frame  = (left_q == CNT_W'(1));
  assign load_o      = accept_o || (frame_end && !last_frame);
  assign shift_o     = busy_q && per_end_i && (slot_q < SLOT_W'(FR_BITS));
  assign busy_o      = busy_q;
  assign in_data_o   = busy_q && (slot_q < SLOT_W'(FR_BITS));
  assign in_strobe_o = busy_q && (slot_q == SLOT_W'(STROBE_SLOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      left_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      slot_q <= '0;
      left_q <= frames_i;
    end else if (frame_end) begin
      slot_q <= '0;
      left_q <= left_q - 1'b1;
      if (last_frame) busy_q <= 1'b0;
    end else if (busy_q && per_end_i) begin
      slot_q <= slot_q + 1'b1;
    end
  end
endmodule

// File: rtl/dds_frame_seq.sv
module dds_frame_seq #(
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DIV_MIN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  frames_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              cs_n_o,
  output logic              ioupd_o,
  output logic              busy_o
);
  import dds_seq_pkg::*;
  localparam int unsigned FR_BITS = CMD_W + WORD_W;
  localparam int unsigned SLOTS   = FR_BITS + GAP_SLOTS + STROBE_SLOTS;
  localparam int unsigned SLOT_W  = clog2_min1(SLOTS);

  logic accept, load, shift, busy, in_data, in_strobe;
  logic per_end, hi_phase, msb;
  ser_pins_t pins_d, pins_q;

  dds_clk_div #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_div (
    .clk(clk), .rst(rst), .load_i(accept), .div_i(div_i), .run_i(busy),
    .per_end_o(per_end), .hi_phase_o(hi_phase)
  );

  dds_frame_ctrl #(.CNT_W(CNT_W), .FR_BITS(FR_BITS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .frames_i(frames_i),
    .per_end_i(per_end), .accept_o(accept), .load_o(load), .shift_o(shift),
    .busy_o(busy), .in_data_o(in_data), .in_strobe_o(in_strobe)
  );

  dds_frame_shift #(.CMD_W(CMD_W), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(load), .shift_i(shift),
    .cmd_i(cmd_i), .word_i(word_i), .msb_o(msb)
  );

  always_comb begin
    pins_d       = PINS_IDLE;
    pins_d.sclk  = in_data && hi_phase;
    pins_d.sdata = in_data && msb;
    pins_d.cs_n  = !in_data;
    pins_d.ioupd = in_strobe;
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_IDLE;
    else     pins_q <= pins_d;
  end

  assign sclk_o  = pins_q.sclk;
  assign sdata_o = pins_q.sdata;
  assign cs_n_o  = pins_q.cs_n;
  assign ioupd_o = pins_q.ioupd;
  assign busy_o  = busy;
endmodule

// File: rtl/dds_frame_seq_chk.sv
module dds_frame_seq_chk #(
  parameter int unsigned DIV_MIN = 5
) (
  input logic clk,
  input logic rst,
  input logic sclk_o,
  input logic sdata_o,
  input logic cs_n_o,
  input logic ioupd_o,
  input logic busy_o
);
  logic [7:0] upd_len;
  always_ff @(posedge clk) begin
    if (rst)          upd_len <= '0;
    else if (ioupd_o) upd_len <= (upd_len == 8'hFF) ? upd_len : upd_len + 1'b1;
    else              upd_len <= '0;
  end

  // R3
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst) sclk_o |-> !cs_n_o);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst) (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  // R6
  strobe_deselected_chk: assert property (@(posedge clk) disable iff (rst) ioupd_o |-> cs_n_o);
  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst) $fell(ioupd_o) |-> (upd_len >= 8'(DIV_MIN)));
  // R7
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> (cs_n_o && !sclk_o && !ioupd_o));
endmodule

bind dds_frame_seq dds_frame_seq_chk #(.DIV_MIN(DIV_MIN)) u_chk (
  .clk(clk), .rst(rst), .sclk_o(sclk_o), .sdata_o(sdata_o),
  .cs_n_o(cs_n_o), .ioupd_o(ioupd_o), .busy_o(busy_o)
);

// File: tb/dds_frame_seq_bench.sv
module dds_frame_seq_bench;
  logic clk = 0, rst = 1, start = 0;
  logic [7:0] div = 8'd5, cmd = '0;
  logic [15:0] frames = '0, word = '0;
  logic sclk_o, sdata_o, cs_n_o, ioupd_o, busy_o;

  always #2 clk = ~clk;

  dds_frame_seq u_dds_frame_seq (
    .clk(clk), .rst(rst), .start_i(start), .div_i(div), .frames_i(frames),
    .cmd_i(cmd), .word_i(word), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .cs_n_o(cs_n_o), .ioupd_o(ioupd_o), .busy_o(busy_o)
  );

  int checks = 0, errors = 0;
  int busy_cyc, bitcnt, fidx, since_rise, rr_min, rr_max, hi_run, hi_min, hi_max;
  int gap_run, gap_min, gap_max, upd_run, upd_min, upd_max, upd_cnt, bad_sclk;
  logic in_gap, p_sclk, p_csn, p_upd;
  logic [23:0] cap;
  logic [23:0] fval [8];
  int fbits [8];

  function automatic int eff_div(input int d);
    return (d < 5) ? 5 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    busy_cyc = 0; bitcnt = 0; fidx = 0; since_rise = 0; cap = '0;
    rr_min = 1 << 30; rr_max = 0; hi_run = 0; hi_min = 1 << 30; hi_max = 0;
    gap_run = 0; gap_min = 1 << 30; gap_max = 0; in_gap = 0;
    upd_run = 0; upd_min = 1 << 30; upd_max = 0; upd_cnt = 0; bad_sclk = 0;
    for (int i = 0; i < 8; i++) begin fval[i] = '0; fbits[i] = 0; end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = 0; p_csn = 1; p_upd = 0;
    end else begin
      if (busy_o) busy_cyc++;
      since_rise++;
      if (sclk_o && !p_sclk && !cs_n_o) begin
        if (bitcnt > 0) begin
          if (since_rise < rr_min) rr_min = since_rise;
          if (since_rise > rr_max) rr_max = since_rise;
        end
        since_rise = 0; cap = {cap[22:0], sdata_o}; bitcnt++;
      end
      if (sclk_o) hi_run++;
      else if (p_sclk) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      if (sclk_o && cs_n_o) bad_sclk++;
      if (cs_n_o && !p_csn) begin
        if (fidx < 8) begin fval[fidx] = cap; fbits[fidx] = bitcnt; end
        fidx++; bitcnt = 0; gap_run = 0; in_gap = 1;
      end
      if (in_gap && cs_n_o && !ioupd_o) gap_run++;
      if (ioupd_o && !p_upd) begin
        if (gap_run < gap_min) gap_min = gap_run;
        if (gap_run > gap_max) gap_max = gap_run;
        in_gap = 0;
      end
      if (ioupd_o) upd_run++;
      else if (p_upd) begin
        if (upd_run < upd_min) upd_min = upd_run;
        if (upd_run > upd_max) upd_max = upd_run;
        upd_cnt++; upd_run = 0;
      end
      p_sclk = sclk_o; p_csn = cs_n_o; p_upd = ioupd_o;
    end
  end

  task automatic pulse_start(input logic [15:0] n);
    @(negedge clk); frames = n; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy_o && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_timing(input int d, input int n, input bit clamp_case);
    int de = eff_div(d);
    chk(busy_cyc == n * 26 * de, "R7 busy cycles", busy_cyc, n * 26 * de);
    chk(fidx == n && upd_cnt == n, "R7 frame/strobe count", {fidx[15:0], upd_cnt[15:0]}, {n[15:0], n[15:0]});
    chk(rr_min == de && rr_max == de, "R4 bit spacing", {rr_min[15:0], rr_max[15:0]}, {de[15:0], de[15:0]});
    chk(hi_min == de / 2 && hi_max == de / 2, "R4 high phase", {hi_min[15:0], hi_max[15:0]}, {16'(de / 2), 16'(de / 2)});
    chk(gap_min == de && gap_max == de, "R6 gap before strobe", {gap_min[15:0], gap_max[15:0]}, {de[15:0], de[15:0]});
    chk(upd_min == de && upd_max == de, "R6 strobe width", {upd_min[15:0], upd_max[15:0]}, {de[15:0], de[15:0]});
    chk(bad_sclk == 0, "R3 sclk outside frame", bad_sclk, 0);
    if (clamp_case) chk(busy_cyc == n * 26 * 5, "R5 divisor clamp", busy_cyc, n * 26 * 5);
  endtask

  task automatic run_burst(input logic [7:0] c, input logic [15:0] w, input logic [7:0] d, input int n);
    @(negedge clk); cmd = c; word = w; div = d;
    clear_stats();
    pulse_start(16'(n));
    wait_idle();
    check_timing(d, n, d < 5);
    for (int i = 0; i < n && i < 8; i++) begin
      chk(fbits[i] == 24, "R2 bit count", fbits[i], 24);
      chk(fval[i] == {c, w}, "R2 frame content", fval[i], {c, w});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_stats();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(cs_n_o && !sclk_o && !sdata_o && !ioupd_o && !busy_o, "R1 reset state",
        {cs_n_o, sclk_o, sdata_o, ioupd_o, busy_o}, 5'b10000);

    // directed corners
    run_burst(8'hA5, 16'h3C0F, 8'd5, 2);
    run_burst(8'h80, 16'h0001, 8'd2, 1);   // R5 clamp
    run_burst(8'h01, 16'h8000, 8'd0, 1);   // R5 zero divisor
    run_burst(8'hFF, 16'hFFFF, 8'd8, 3);

    // R8 mid-frame change and R9 start while busy
    @(negedge clk); cmd = 8'h3E; word = 16'h1234; div = 8'd6;
    clear_stats();
    pulse_start(16'd3);
    while (cs_n_o) @(negedge clk);
    repeat (10) @(negedge clk);
    cmd = 8'hC1; word = 16'hBEEF;
    pulse_start(16'd5);
    wait_idle();
    chk(fval[0] == {8'h3E, 16'h1234}, "R8 first frame keeps old value", fval[0], {8'h3E, 16'h1234});
    chk(fval[1] == {8'hC1, 16'hBEEF}, "R8 second frame takes new value", fval[1], {8'hC1, 16'hBEEF});
    chk(fval[2] == {8'hC1, 16'hBEEF}, "R8 third frame new value", fval[2], {8'hC1, 16'hBEEF});
    chk(busy_cyc == 3 * 26 * 6, "R9 start while busy ignored", busy_cyc, 3 * 26 * 6);

    // R9 zero frame count
    clear_stats();
    pulse_start(16'd0);
    repeat (20) @(negedge clk);
    chk(busy_cyc == 0 && fidx == 0 && cs_n_o, "R9 zero count ignored", busy_cyc, 0);

    // constrained random bursts
    for (int k = 0; k < 8; k++) begin
      logic [7:0] rc, rd;
      logic [15:0] rw;
      int rn;
      rc = 8'($urandom); rw = 16'($urandom);
      rd = 8'($urandom_range(0, 10)); rn = $urandom_range(1, 3);
      run_burst(rc, rw, rd, rn);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule